// File: doc/BRIEF.md
# Double-Data-Rate Input Capture Register

This block takes a pad signal that carries a new bit on both the rising and the falling edge of one clock, and turns it into two single-rate outputs for the fabric. `cap_first` holds the bit taken on the rising edge. `cap_second` holds the bit taken on the falling edge. A compile-time parameter chooses how the two bits are presented. In opposite-edge alignment each output changes on the edge that captured it. In same-edge alignment both outputs change only on the rising edge. In pipelined same-edge alignment both outputs change on the rising edge, and the two bits of one rising/falling pair always come out together; the price is one extra cycle of latency on `cap_first`.

A companion transmit path does the reverse. It takes two fabric bits, `tx_first` and `tx_second`, and drives `tx_first` on `pad_out` while the clock is high and `tx_second` while it is low. The transmit path has only two alignments: opposite edge and same edge. When the receive alignment is pipelined, the transmit path uses same-edge alignment.

A synchronous reset and a clock enable act on every register, on both clock edges. All data ports are `WIDTH` bits wide, and every bit lane is handled independently. The block is a plain per-cycle register with no stream handshake. A bit is consumed on every clock edge at which `clk_en` is high, and a held value stays on the outputs for as long as `clk_en` stays low. Nothing in the block can apply back-pressure.

Top module: `ddr_capture_reg`

## Requirements
- R1: When `rst` is high on a rising edge, that edge clears every rising-edge register, whatever the state of `clk_en`. When `rst` is high on a falling edge, that edge clears every falling-edge register. After two full cycles of reset, `cap_first`, `cap_second` and `pad_out` are all zero in both clock phases.
- R2: With `MODE` = 0 (opposite edge), `cap_first` shows the `pad_in` value taken at the latest rising edge and changes only at rising edges. `cap_second` shows the value taken at the latest falling edge and changes only at falling edges.
- R3: With `MODE` = 1 (same edge), `cap_first` shows the value taken at the latest rising edge. `cap_second` shows the value taken at the falling edge that came just before that rising edge. Both outputs change only at rising edges.
- R4: With `MODE` = 2 (pipelined same edge), the outputs after rising edge k+1 are the rising-edge bit of cycle k on `cap_first` and the falling-edge bit of cycle k on `cap_second`. The pair is aligned, and `cap_first` lags by one more cycle than in `MODE` = 1.
- R5: While `clk_en` is low across a whole cycle and `rst` is low, every output holds in both clock phases, and the bits offered on `pad_in`, `tx_first` and `tx_second` are ignored.
- R6: With `MODE` = 0, `pad_out` carries `tx_first` as sampled at a rising edge for the high phase that follows. It carries `tx_second` as sampled at the next falling edge for the low phase that follows.
- R7: With `MODE` = 1 or 2, `tx_first` and `tx_second` are both sampled at the rising edge. `pad_out` carries `tx_first` during the following high phase and the `tx_second` sampled at that same rising edge during the following low phase. A change of `tx_second` after that rising edge has no effect until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high, sampled on both edges |
| clk_en | input | 1 | Clock enable for every register |
| pad_in | input | WIDTH | Double-rate input lanes |
| cap_first | output | WIDTH | Bit captured on the rising edge |
| cap_second | output | WIDTH | Bit captured on the falling edge |
| tx_first | input | WIDTH | Fabric bit for the high phase of `pad_out` |
| tx_second | input | WIDTH | Fabric bit for the low phase of `pad_out` |
| pad_out | output | WIDTH | Double-rate output lanes |

## Verification
The bench runs all three alignment modes side by side on one stream, with different bits on each edge. It checks the outputs in both clock phases. This catches a same-edge design that lets `cap_second` move at the falling edge, which is exactly what opposite-edge mode should do instead. It also catches a pipelined design that skips the extra `cap_first` stage and so splits the pair across two cycles. The bench changes `tx_second` between the rising and the falling edge, so that a transmit path sampling at the wrong edge puts the wrong bit on `pad_out` during the low phase. Runs of disabled cycles, and a reset held while `clk_en` is low, expose a register that ignores the enable, or a falling-edge register that the reset does not clear.

// File: rtl/ddr_capture_pkg.sv
package ddr_capture_pkg;
  // Alignment selection for the receive side
  localparam int ALIGN_OPPOSITE  = 0;
  localparam int ALIGN_SAME      = 1;
  localparam int ALIGN_SAME_PIPE = 2;

  function automatic bit tx_uses_same_edge(int mode);
    return mode != ALIGN_OPPOSITE;
  endfunction
endpackage

// File: rtl/ddr_edge_sampler.sv
module ddr_edge_sampler #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] rise_bit,
  output logic [WIDTH-1:0] fall_bit
);
  always_ff @(posedge clk) begin
    if (rst)         rise_bit <= '0;
    else if (clk_en) rise_bit <= pad_in;
  end

  always_ff @(negedge clk) begin
    if (rst)         fall_bit <= '0;
    else if (clk_en) fall_bit <= pad_in;
  end

  AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> rise_bit == $past(pad_in)); // R2
  AST_FALL_CAPTURE: assert property (@(negedge clk) disable iff (rst)
    clk_en |=> fall_bit == $past(pad_in)); // R2
endmodule

// File: rtl/ddr_pad_driver.sv
module ddr_pad_driver #(
  parameter int WIDTH     = 1,
  parameter bit SAME_EDGE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic [WIDTH-1:0] tx_first,
  input  logic [WIDTH-1:0] tx_second,
  output logic [WIDTH-1:0] pad_out
);
  logic [WIDTH-1:0] hi_phase;
  logic [WIDTH-1:0] lo_phase;

  always_ff @(posedge clk) begin
    if (rst)         hi_phase <= '0;
    else if (clk_en) hi_phase <= tx_first;
  end

  generate
    if (SAME_EDGE) begin : g_same
      logic [WIDTH-1:0] second_stage;
      always_ff @(posedge clk) begin
        if (rst)         second_stage <= '0;
        else if (clk_en) second_stage <= tx_second;
      end
      always_ff @(negedge clk) begin
        if (rst)         lo_phase <= '0;
        else if (clk_en) lo_phase <= second_stage;
      end
    end else begin : g_opposite
      always_ff @(negedge clk) begin
        if (rst)         lo_phase <= '0;
        else if (clk_en) lo_phase <= tx_second;
      end
    end
  endgenerate

  // Phase mux: high half-cycle shows the rising-edge bit
  assign pad_out = clk ? hi_phase : lo_phase;

  AST_DRIVE_HOLD_HI: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(hi_phase)); // R5
  AST_DRIVE_HOLD_LO: assert property (@(negedge clk) disable iff (rst)
    !clk_en |=> $stable(lo_phase)); // R5
endmodule

// File: rtl/ddr_capture_reg.sv
module ddr_capture_reg
  import ddr_capture_pkg::*;
#(
  parameter int WIDTH = 1,
  parameter int MODE  = ALIGN_OPPOSITE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] cap_first,
  output logic [WIDTH-1:0] cap_second,
  input  logic [WIDTH-1:0] tx_first,
  input  logic [WIDTH-1:0] tx_second,
  output logic [WIDTH-1:0] pad_out
);
  localparam bit TX_SAME = tx_uses_same_edge(MODE);

  logic [WIDTH-1:0] rise_bit;
  logic [WIDTH-1:0] fall_bit;

  ddr_edge_sampler #(.WIDTH(WIDTH)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .pad_in   (pad_in),
    .rise_bit (rise_bit),
    .fall_bit (fall_bit)
  );

  generate
    if (MODE == ALIGN_OPPOSITE) begin : g_opposite
      assign cap_first  = rise_bit;
      assign cap_second = fall_bit;
    end else if (MODE == ALIGN_SAME) begin : g_same
      logic [WIDTH-1:0] fall_realign;
      always_ff @(posedge clk) begin
        if (rst)         fall_realign <= '0;
        else if (clk_en) fall_realign <= fall_bit;
      end
      assign cap_first  = rise_bit;
      assign cap_second = fall_realign;
    end else begin : g_same_pipe
      logic [WIDTH-1:0] fall_realign;
      logic [WIDTH-1:0] rise_delay;
      always_ff @(posedge clk) begin
        if (rst) begin
          fall_realign <= '0;
          rise_delay   <= '0;
        end else if (clk_en) begin
          fall_realign <= fall_bit;
          rise_delay   <= rise_bit;
        end
      end
      assign cap_first  = rise_delay;
      assign cap_second = fall_realign;

      AST_PIPE_FIRST_LAG: assert property (@(posedge clk) disable iff (rst)
        (clk_en && $past(clk_en) && !$past(rst)) |=> cap_first == $past(pad_in, 2)); // R4
    end
  endgenerate

  ddr_pad_driver #(.WIDTH(WIDTH), .SAME_EDGE(TX_SAME)) u_driver (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .tx_first  (tx_first),
    .tx_second (tx_second),
    .pad_out   (pad_out)
  );

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(cap_first)); // R5
endmodule

// File: tb/test_ddr_capture_reg.sv
`timescale 1ns/100ps
module test_ddr_capture_reg;
  localparam int W = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic         rst = 1'b1;
  logic         ce  = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] d1  = '0;
  logic [W-1:0] d2  = '0;
  logic [W-1:0] q1_w [3];
  logic [W-1:0] q2_w [3];
  logic [W-1:0] dq_w [3];

  for (genvar m = 0; m < 3; m++) begin : g_mode
    ddr_capture_reg #(.WIDTH(W), .MODE(m)) i_ddr_capture_reg (
      .clk        (clk),
      .rst        (rst),
      .clk_en     (ce),
      .pad_in     (din),
      .cap_first  (q1_w[m]),
      .cap_second (q2_w[m]),
      .tx_first   (d1),
      .tx_second  (d2),
      .pad_out    (dq_w[m])
    );
  end

  typedef struct packed {
    bit               skip;
    logic [1:0]       kind;  // 0 normal, 1 hold, 2 reset
    logic [2:0][W-1:0] q1;
    logic [2:0][W-1:0] q2;
    logic [2:0][W-1:0] dq;
  } exp_t;

  exp_t sb[$];
  exp_t last_hi, last_lo;
  bit [W-1:0] hr[$], hf[$], ha[$], hb[$], he[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit rst_prev = 1'b1;
  bit finished = 1'b0;

  function automatic string req_tag(logic [1:0] kind, int m, bit is_tx);
    if (kind == 2) return "R1";
    if (kind == 1) return "R5";
    if (is_tx) return (m == 0) ? "R6" : "R7";
    return (m == 0) ? "R2" : ((m == 1) ? "R3" : "R4");
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: pops one expectation per clock phase
  initial begin
    exp_t e;
    forever begin
      @(clk);
      #1.5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        if (!e.skip) begin
          for (int m = 0; m < 3; m++) begin
            chk(req_tag(e.kind, m, 1'b0), $sformatf("mode%0d cap_first", m),  q1_w[m], e.q1[m]);
            chk(req_tag(e.kind, m, 1'b0), $sformatf("mode%0d cap_second", m), q2_w[m], e.q2[m]);
            chk(req_tag(e.kind, m, 1'b1), $sformatf("mode%0d pad_out", m),    dq_w[m], e.dq[m]);
          end
        end
      end
    end
  end

  // Driver: one full clock cycle, entered just after a falling edge
  task automatic step(input bit [W-1:0] r, input bit [W-1:0] a, input bit [W-1:0] b,
                      input bit [W-1:0] f, input bit [W-1:0] e2, input bit c, input bit rs);
    exp_t x;
    int n;
    #0.5;
    din = r; d1 = a; d2 = b; ce = c; rst = rs;
    @(posedge clk);
    x = '0;
    if (rs) begin
      x.kind = 2;
      x.skip = !rst_prev;  // falling-edge registers clear only at the next falling edge
      hr.push_back('0); ha.push_back('0); hb.push_back('0);
    end else if (!c) begin
      x = last_lo;
      x.kind = 1;
      for (int m = 0; m < 3; m++) x.dq[m] = last_hi.dq[m];
    end else begin
      hr.push_back(r); ha.push_back(a); hb.push_back(b);
      n = hr.size() - 1;
      for (int m = 0; m < 3; m++) begin
        x.q1[m] = (m == 2) ? hr[n-1] : hr[n];
        x.q2[m] = hf[n-1];
        x.dq[m] = ha[n];
      end
    end
    last_hi = x;
    sb.push_back(x);
    #0.5;
    din = f; d2 = e2;
    @(negedge clk);
    x = '0;
    if (rs) begin
      x.kind = 2;
      hf.push_back('0); he.push_back('0);
    end else if (!c) begin
      x = last_lo;
      x.kind = 1;
    end else begin
      hf.push_back(f); he.push_back(e2);
      n = hf.size() - 1;
      for (int m = 0; m < 3; m++) begin
        x.q1[m] = (m == 2) ? hr[n-1] : hr[n];
        x.q2[m] = (m == 0) ? hf[n] : hf[n-1];
        x.dq[m] = (m == 0) ? he[n] : hb[n];
      end
    end
    rst_prev = rs;
    last_lo  = x;
    sb.push_back(x);
  endtask

  task automatic rnd_step(input bit c);
    step(W'($urandom), W'($urandom), W'($urandom), W'($urandom), W'($urandom), c, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished at %0t", $time);
    summary();
  end

  initial begin
    rst = 1'b1; ce = 1'b0;
    repeat (3) @(negedge clk);
    #1.5;
    for (int m = 0; m < 3; m++) begin
      chk("R1", $sformatf("mode%0d reset cap_first", m),  q1_w[m], '0);
      chk("R1", $sformatf("mode%0d reset cap_second", m), q2_w[m], '0);
      chk("R1", $sformatf("mode%0d reset pad_out", m),    dq_w[m], '0);
    end
    @(negedge clk);
    hr.push_back('0); hf.push_back('0); ha.push_back('0); hb.push_back('0); he.push_back('0);
    // random stream with enable gaps (R2 R3 R4 R6 R7, gaps R5)
    for (int i = 0; i < 30; i++) rnd_step(!(i == 10 || i == 11 || i == 20));
    // alternating rising/falling pattern, tx_second changed mid-cycle (R7 vs R6)
    for (int i = 0; i < 6; i++) step(2'b01, 2'b10, 2'b11, 2'b10, 2'b00, 1'b1, 1'b0);
    // reset while enable low (R1)
    step(2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1);
    step(2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) rnd_step(i != 5);
    // all ones then walking lanes
    for (int i = 0; i < 4; i++) step(2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(W'(1 << (i % W)), W'(i), W'(3 - i), W'(2 >> (i % W)), W'(i + 1), 1'b1, 1'b0);
    #3;
    summary();
  end
endmodule